// File: doc/BRIEF.md
# ADC acquisition sequencer with averaging

This controller runs an external analog-to-digital converter through a measurement. It powers the converter, issues a one-cycle start strobe with a channel number, waits out the conversion time set by the amplifier setting, and takes the result over a valid/data handshake. Each result goes to an output FIFO as a raw sample. In the burst modes it can instead be folded into a running sum, and only the burst average is written.

Four acquisition modes are selected by `mode_i`. Continuous mode repeats list entry 0 until the enable drops. Burst mode takes 2^k samples of entry 0. Scan mode converts each list entry once, in list order. Scan-with-burst mode finishes a whole burst on one entry before it moves to the next. A programmable gap is inserted between samples. In low-power mode the converter is switched off during that gap and is given a wake-up interval before each strobe. The enable is a level: it must stay high for a measurement to run and be lowered before a new one can start.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is asserted and after it is released with `en_i` low, `adc_pwr_o`, `adc_soc_o`, `fifo_push_o`, `done_o` and `ovf_o` are all low.
- R2: Mode 0 (continuous) converts list entry 0 repeatedly and never pulses `done_o`. It keeps running until `en_i` is lowered.
- R3: Mode 1 (burst) takes 2^k samples of list entry 0, where k = `burst_log2_i` and values above 8 count as 8. It then pulses `done_o` for one cycle, switches the converter off and holds until `en_i` is lowered.
- R4: Mode 2 (scan) converts entries 0 to `list_last_i` once each, in increasing index order. Entry i sits in `list_i[4i+3:4i]`. One `done_o` pulse follows the last entry.
- R5: Mode 3 (scan with burst) completes the full burst, and the average if enabled, on one entry before it starts the next entry.
- R6: With `avg_en_i`=1 in modes 1 and 3, a single word is pushed per burst, holding floor(sum of the burst / 2^k). With `avg_en_i`=0, or in modes 0 and 2, every sample is pushed raw.
- R7: A result is accepted at the first clock edge at least C cycles after the strobe cycle at which `adc_valid_i` is high. C is 16 with the amplifier bypassed, and otherwise 17, 17, 18 or 19 for `pga_gain_i` = 0, 1, 2 or 3. An earlier valid is ignored, and a late valid is waited for.
- R8: Between two samples of a measurement, the controller spends `gap_i` cycles idle before it launches the next conversion.
- R9: With `low_power_i`=1, `adc_pwr_o` is low during the gap and rises `wake_i` cycles before each strobe. With `low_power_i`=0 it stays high from start to the end of the measurement.
- R10: A result that would be pushed while `fifo_full_i` is high is dropped, and `ovf_o` is set. `ovf_o` stays high until `ovf_clr_i` is pulsed.
- R11: With `repeat_i`=1, a burst or scan measurement restarts right after it ends and pulses `done_o` once per pass.
- R12: `fifo_data_o` holds the channel in bits [15:12] and the 12-bit value in bits [11:0]. It is valid while `fifo_push_o` is high for one cycle.
- R13: Lowering `en_i` stops the controller from any state. The converter is switched off on the next cycle and no further words are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Measurement enable (level) |
| mode_i | input | 2 | 0 continuous, 1 burst, 2 scan, 3 scan with burst |
| repeat_i | input | 1 | Restart burst/scan measurement when it ends |
| list_i | input | 32 | Eight 4-bit channel entries, entry 0 in the low bits |
| list_last_i | input | 3 | Index of the last list entry used by scan |
| burst_log2_i | input | 4 | Burst length exponent k |
| gap_i | input | 8 | Idle cycles between samples |
| avg_en_i | input | 1 | Push the burst average instead of raw samples |
| pga_bypass_i | input | 1 | Amplifier bypassed |
| pga_gain_i | input | 2 | Amplifier gain code: 1x, 2x, 4x, 8x |
| low_power_i | input | 1 | Switch the converter off between samples |
| wake_i | input | 8 | Wake-up cycles after power-on before the strobe |
| adc_pwr_o | output | 1 | Converter power enable |
| adc_soc_o | output | 1 | Start-of-conversion strobe |
| adc_chan_o | output | 4 | Channel to convert |
| adc_valid_i | input | 1 | Converter result valid |
| adc_data_i | input | 12 | Converter result |
| fifo_full_i | input | 1 | Output FIFO full |
| fifo_push_o | output | 1 | Write strobe to the FIFO |
| fifo_data_o | output | 16 | Word written to the FIFO |
| done_o | output | 1 | One-cycle pulse when a measurement pass ends |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |

## Verification
Most internal faults show at the ports within a single conversion. A bad wait counter moves the start strobe or the FIFO write by one or more cycles. A bad list index shows a wrong channel on the strobe cycle or in bits [15:12] of the pushed word. A bad burst counter or accumulator does not show until the last sample of a burst, where the count of writes or the averaged value is wrong. For a 256-sample burst that is several thousand cycles later. A power sequencing fault shows as `adc_pwr_o` differing from the model during the gap or the wake interval. Because the bench compares all these outputs every cycle, the first wrong cycle is reported.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_CONT       = 2'd0,
    MODE_BURST      = 2'd1,
    MODE_SCAN       = 2'd2,
    MODE_SCAN_BURST = 2'd3
  } acq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SOC,
    ST_CONV,
    ST_GAP,
    ST_HALT
  } seq_state_e;

  // conversion length in cycles for the amplifier setting
  function automatic logic [4:0] conv_len(input logic bypass, input logic [1:0] gain);
    if (bypass) return 5'd16;
    case (gain)
      2'd2:    return 5'd18;
      2'd3:    return 5'd19;
      default: return 5'd17;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_chan_sel.sv
module adc_seq_chan_sel #(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [DEPTH*CHAN_W-1:0] list_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [CHAN_W-1:0]       chan_o
);

  logic [CHAN_W-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign entry[g] = list_i[g*CHAN_W +: CHAN_W];
  end

  assign chan_o = entry[idx_i];

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG  = 8,
  parameter int LOG_W    = 4,
  localparam int ACC_W   = SAMPLE_W + MAX_LOG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [LOG_W-1:0]    shift_i,
  output logic [SAMPLE_W-1:0] avg_o
);

  logic [ACC_W-1:0] acc_q, sum;

  assign sum   = acc_q + ACC_W'(sample_i);
  assign avg_o = SAMPLE_W'(sum >> shift_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= sum;
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int CHAN_W     = 4,
  parameter int LIST_DEPTH = 8,
  parameter int MAX_LOG    = 8,
  parameter int DLY_W      = 8,
  localparam int IDX_W     = $clog2(LIST_DEPTH),
  localparam int LOG_W     = $clog2(MAX_LOG + 1),
  localparam int WORD_W    = CHAN_W + SAMPLE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [1:0]                   mode_i,
  input  logic                         repeat_i,
  input  logic [LIST_DEPTH*CHAN_W-1:0] list_i,
  input  logic [IDX_W-1:0]             list_last_i,
  input  logic [LOG_W-1:0]             burst_log2_i,
  input  logic [DLY_W-1:0]             gap_i,
  input  logic                         avg_en_i,
  input  logic                         pga_bypass_i,
  input  logic [1:0]                   pga_gain_i,
  input  logic                         low_power_i,
  input  logic [DLY_W-1:0]             wake_i,
  output logic                         adc_pwr_o,
  output logic                         adc_soc_o,
  output logic [CHAN_W-1:0]            adc_chan_o,
  input  logic                         adc_valid_i,
  input  logic [SAMPLE_W-1:0]          adc_data_i,
  input  logic                         fifo_full_i,
  output logic                         fifo_push_o,
  output logic [WORD_W-1:0]            fifo_data_o,
  output logic                         done_o,
  output logic                         ovf_o,
  input  logic                         ovf_clr_i
);

  localparam int SMP_W = MAX_LOG + 1;
  localparam int CNT_W = (DLY_W > 5) ? DLY_W : 5;

  seq_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SMP_W-1:0]  smp_q;
  logic              pwr_q, push_q, done_q, ovf_q;
  logic [WORD_W-1:0] data_q;

  acq_mode_e         mode;
  logic              is_burst, is_scan, averaging;
  logic [LOG_W-1:0]  log_eff;
  logic [SMP_W-1:0]  smp_max;
  logic              burst_last, chan_last, pass_end, stop;
  logic              capture, push_want;
  logic [SAMPLE_W-1:0] avg, result;
  logic              use_wake;
  seq_state_e        launch_st;
  logic [CNT_W-1:0]  launch_cnt;

  assign mode       = acq_mode_e'(mode_i);
  assign is_burst   = (mode == MODE_BURST) || (mode == MODE_SCAN_BURST);
  assign is_scan    = (mode == MODE_SCAN) || (mode == MODE_SCAN_BURST);
  assign averaging  = is_burst && avg_en_i;
  assign log_eff    = (burst_log2_i > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : burst_log2_i;
  assign smp_max    = is_burst ? ((SMP_W'(1) << log_eff) - SMP_W'(1)) : '0;
  assign burst_last = (smp_q == smp_max);
  assign chan_last  = !is_scan || (idx_q == list_last_i);
  assign pass_end   = burst_last && chan_last;
  assign stop       = pass_end && !(repeat_i || mode == MODE_CONT);
  assign capture    = (st_q == ST_CONV) && (cnt_q == '0) && adc_valid_i && en_i;
  assign push_want  = capture && (!averaging || burst_last);
  assign result     = averaging ? avg : adc_data_i;

  // a conversion begins with an optional wake-up interval in low-power mode
  assign use_wake   = low_power_i && (wake_i != '0);
  assign launch_st  = use_wake ? ST_WAKE : ST_SOC;
  assign launch_cnt = CNT_W'(wake_i);

  adc_seq_chan_sel #(
    .DEPTH (LIST_DEPTH),
    .CHAN_W(CHAN_W),
    .IDX_W (IDX_W)
  ) u_chan_sel (
    .list_i(list_i),
    .idx_i (idx_q),
    .chan_o(adc_chan_o)
  );

  adc_seq_avg #(
    .SAMPLE_W(SAMPLE_W),
    .MAX_LOG (MAX_LOG),
    .LOG_W   (LOG_W)
  ) u_avg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i || (capture && burst_last)),
    .add_i   (capture),
    .sample_i(adc_data_i),
    .shift_i (log_eff),
    .avg_o   (avg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      smp_q  <= '0;
      pwr_q  <= 1'b0;
      push_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      data_q <= '0;
    end else begin
      push_q <= 1'b0;
      done_q <= 1'b0;
      if (ovf_clr_i) ovf_q <= 1'b0;
      if (!en_i) begin
        st_q  <= ST_IDLE;
        pwr_q <= 1'b0;
        idx_q <= '0;
        smp_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            pwr_q <= 1'b1;
            st_q  <= launch_st;
            cnt_q <= launch_cnt;
          end
          ST_WAKE: begin
            if (cnt_q == CNT_W'(1)) st_q <= ST_SOC;
            else                    cnt_q <= cnt_q - 1'b1;
          end
          ST_SOC: begin
            st_q  <= ST_CONV;
            cnt_q <= CNT_W'(conv_len(pga_bypass_i, pga_gain_i) - 5'd1);
          end
          ST_CONV: begin
            if (cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (adc_valid_i) begin
              if (push_want) begin
                if (fifo_full_i) ovf_q <= 1'b1;
                else begin
                  push_q <= 1'b1;
                  data_q <= {adc_chan_o, result};
                end
              end
              done_q <= pass_end && (mode != MODE_CONT);
              if (burst_last) begin
                smp_q <= '0;
                idx_q <= chan_last ? '0 : idx_q + 1'b1;
              end else begin
                smp_q <= smp_q + 1'b1;
              end
              if (stop) begin
                st_q  <= ST_HALT;
                pwr_q <= 1'b0;
              end else if (gap_i != '0) begin
                st_q  <= ST_GAP;
                cnt_q <= CNT_W'(gap_i);
                if (low_power_i) pwr_q <= 1'b0;
              end else begin
                st_q  <= launch_st;
                cnt_q <= launch_cnt;
              end
            end
          end
          ST_GAP: begin
            if (cnt_q == CNT_W'(1)) begin
              pwr_q <= 1'b1;
              st_q  <= launch_st;
              cnt_q <= launch_cnt;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: st_q <= ST_HALT;
        endcase
      end
    end
  end

  assign adc_pwr_o   = pwr_q;
  assign adc_soc_o   = (st_q == ST_SOC);
  assign fifo_push_o = push_q;
  assign fifo_data_o = data_q;
  assign done_o      = done_q;
  assign ovf_o       = ovf_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CHAN_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              adc_pwr_o,
  input logic              adc_soc_o,
  input logic [CHAN_W-1:0] adc_chan_o,
  input logic              fifo_push_o,
  input logic              done_o,
  input logic              ovf_o,
  input logic              ovf_clr_i
);

  logic [5:0] since_soc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_soc_q <= '0;
    else if (adc_soc_o)         since_soc_q <= 6'd1;
    else if (since_soc_q != '1) since_soc_q <= since_soc_q + 1'b1;
  end

  assert_soc_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_soc_o |=> !adc_soc_o);

  assert_chan_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_soc_o |=> $stable(adc_chan_o));

  assert_result_not_early_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_push_o || done_o) |-> (since_soc_q >= 6'd17));

  assert_soc_powered_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_soc_o |-> adc_pwr_o);

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_stop_power_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !adc_pwr_o);

  assert_stop_push_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> $past(en_i));

endmodule

bind adc_seq_top adc_seq_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .adc_pwr_o  (adc_pwr_o),
  .adc_soc_o  (adc_soc_o),
  .adc_chan_o (adc_chan_o),
  .fifo_push_o(fifo_push_o),
  .done_o     (done_o),
  .ovf_o      (ovf_o),
  .ovf_clr_i  (ovf_clr_i)
);

// File: tb/adc_seq_top_test.sv
`timescale 1ns/1ps
module adc_seq_top_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        repeat_i = 1'b0;
  logic [31:0] list_i = 32'h92C73E15;
  logic [2:0]  list_last_i = 3'd0;
  logic [3:0]  burst_log2_i = 4'd0;
  logic [7:0]  gap_i = 8'd0;
  logic        avg_en_i = 1'b0;
  logic        pga_bypass_i = 1'b1;
  logic [1:0]  pga_gain_i = 2'd0;
  logic        low_power_i = 1'b0;
  logic [7:0]  wake_i = 8'd0;
  logic        adc_valid_i = 1'b0;
  logic [11:0] adc_data_i = 12'd0;
  logic        fifo_full_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic        adc_pwr_o, adc_soc_o, fifo_push_o, done_o, ovf_o;
  logic [3:0]  adc_chan_o;
  logic [15:0] fifo_data_o;

  always #5 clk = ~clk;

  adc_seq_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .repeat_i(repeat_i),
    .list_i(list_i), .list_last_i(list_last_i), .burst_log2_i(burst_log2_i),
    .gap_i(gap_i), .avg_en_i(avg_en_i), .pga_bypass_i(pga_bypass_i),
    .pga_gain_i(pga_gain_i), .low_power_i(low_power_i), .wake_i(wake_i),
    .adc_pwr_o(adc_pwr_o), .adc_soc_o(adc_soc_o), .adc_chan_o(adc_chan_o),
    .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i), .fifo_full_i(fifo_full_i),
    .fifo_push_o(fifo_push_o), .fifo_data_o(fifo_data_o), .done_o(done_o),
    .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";
  int    extra = 0;
  bit    junk = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] val(int ch, int n);
    return 12'((ch * 293 + n * 1117) % 4096);
  endfunction

  function automatic int conv_cycles();
    if (pga_bypass_i) return 16;
    if (pga_gain_i == 2'd3) return 19;
    if (pga_gain_i == 2'd2) return 18;
    return 17;
  endfunction

  function automatic int entry(int i);
    return int'(list_i[i*4 +: 4]);
  endfunction

  // converter stand-in
  int cv_cnt = 0, cv_len = 0, conv_n = 0;
  logic [11:0] cv_data = 12'd0;
  always @(negedge clk) begin
    adc_valid_i = 1'b0;
    if (cv_cnt > 0) begin
      cv_cnt--;
      if (cv_cnt == 0) begin
        adc_valid_i = 1'b1;
        adc_data_i  = cv_data;
      end else if (junk && cv_cnt == cv_len - 3) begin
        adc_valid_i = 1'b1;
        adc_data_i  = 12'hABC;
      end
    end
    if (adc_soc_o) begin
      cv_len  = conv_cycles() + extra;
      cv_cnt  = cv_len;
      cv_data = val(int'(adc_chan_o), conv_n);
      conv_n++;
    end
  end

  // reference model
  logic exp_pwr = 0, exp_soc = 0, exp_push = 0, exp_done = 0, exp_ovf = 0;
  int   exp_chan = 0;
  logic [15:0] exp_data = 16'd0;
  bit   ab = 0, halted = 0, cmp_on = 0;
  int   nconv = 0;

  always @(posedge clk) begin
    #1;
    if (rst_ni && ovf_clr_i) exp_ovf = 1'b0;
  end

  task automatic step();
    if (ab) return;
    @(posedge clk); #2;
    exp_push = 0; exp_done = 0; exp_soc = 0;
    if (!en_i) begin
      ab = 1; exp_pwr = 0;
    end
  endtask

  task automatic run_model();
    int  k, n_ch, nb, sum, v, ch;
    bit  bur, avg, last_b, last_pass, cont;
    cont = (mode_i == 2'd0);
    bur  = (mode_i == 2'd1) || (mode_i == 2'd3);
    k    = (burst_log2_i > 8) ? 8 : int'(burst_log2_i);
    nb   = bur ? (1 << k) : 1;
    n_ch = (mode_i[1]) ? int'(list_last_i) + 1 : 1;
    avg  = bur && avg_en_i;
    forever begin
      for (int c = 0; c < n_ch; c++) begin
        sum = 0;
        for (int b = 0; b < nb; b++) begin
          if (ab) return;
          exp_pwr = 1;
          if (low_power_i && wake_i != 0) repeat (int'(wake_i)) step();
          if (ab) return;
          ch = entry(c);
          exp_soc = 1; exp_chan = ch;
          v = int'(val(ch, nconv)); nconv++;
          step();
          repeat (conv_cycles() - 1 + extra) step();
          step();
          if (ab) return;
          sum += v;
          last_b    = (b == nb - 1);
          last_pass = last_b && (c == n_ch - 1);
          if (!avg || last_b) begin
            if (fifo_full_i) exp_ovf = 1;
            else begin
              exp_push = 1;
              exp_data = {4'(ch), avg ? 12'(sum >> k) : 12'(v)};
            end
          end
          if (last_pass && !cont) exp_done = 1;
          if (last_pass && !(repeat_i || cont)) begin
            exp_pwr = 0; halted = 1;
            while (!ab) step();
            return;
          end
          if (gap_i != 0) begin
            if (low_power_i) exp_pwr = 0;
            repeat (int'(gap_i)) step();
          end
        end
      end
    end
  endtask

  initial begin
    @(posedge rst_ni);
    forever begin
      ab = 0; halted = 0; exp_pwr = 0;
      do begin
        @(posedge clk); #2;
        exp_push = 0; exp_done = 0; exp_soc = 0;
      end while (!en_i);
      run_model();
    end
  end

  int n_push = 0, n_done = 0;
  logic [15:0] last_word = 16'd0;
  always @(negedge clk) begin
    if (fifo_push_o) begin n_push++; last_word = fifo_data_o; end
    if (done_o) n_done++;
    if (rst_ni && cmp_on) begin
      chk(adc_soc_o === exp_soc, tag, "strobe R7", adc_soc_o, exp_soc);
      if (exp_soc) chk(int'(adc_chan_o) == exp_chan, tag, "channel R4", adc_chan_o, exp_chan);
      chk(adc_pwr_o === exp_pwr, tag, "power R9", adc_pwr_o, exp_pwr);
      chk(fifo_push_o === exp_push, tag, "push R12", fifo_push_o, exp_push);
      if (exp_push) chk(fifo_data_o === exp_data, tag, "word R12", fifo_data_o, exp_data);
      chk(done_o === exp_done, tag, "done R3", done_o, exp_done);
      chk(ovf_o === exp_ovf, tag, "overflow R10", ovf_o, exp_ovf);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic cfg(input logic [1:0] m, input int last, input int k, input int gap,
                     input bit av, input bit byp, input int gain, input bit lp,
                     input int wk, input bit rep, input int ex, input bit jk);
    mode_i = m; list_last_i = 3'(last); burst_log2_i = 4'(k); gap_i = 8'(gap);
    avg_en_i = av; pga_bypass_i = byp; pga_gain_i = 2'(gain); low_power_i = lp;
    wake_i = 8'(wk); repeat_i = rep; extra = ex; junk = jk;
    n_push = 0; n_done = 0;
  endtask

  task automatic finish_pass();
    while (!halted) tick();
    en_i = 1'b0;
    repeat (5) tick();
  endtask

  initial begin
    repeat (3) tick();
    chk(!adc_pwr_o && !adc_soc_o && !fifo_push_o && !done_o && !ovf_o, "R1", "reset outputs", 
        {adc_pwr_o, adc_soc_o, fifo_push_o, done_o, ovf_o}, 0);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    repeat (4) tick();
    chk(!adc_pwr_o && !adc_soc_o, "R1", "idle after reset", {adc_pwr_o, adc_soc_o}, 0);

    // R2 continuous
    tag = "R2"; cfg(2'd0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    en_i = 1'b1;
    while (n_push < 5) tick();
    en_i = 1'b0;
    repeat (40) tick();
    chk(n_push == 5, "R2", "continuous push count", n_push, 5);
    chk(n_done == 0, "R2", "continuous done count", n_done, 0);
    chk(last_word[15:12] == 4'h5, "R2", "continuous channel", last_word[15:12], 5);

    // R3 / R8 burst raw with gap
    tag = "R8"; cfg(2'd1, 0, 2, 3, 0, 0, 2, 0, 0, 0, 0, 0);
    en_i = 1'b1; finish_pass();
    chk(n_push == 4, "R3", "burst push count", n_push, 4);
    chk(n_done == 1, "R3", "burst done count", n_done, 1);

    // R6 burst averaged
    tag = "R6"; cfg(2'd1, 0, 3, 1, 1, 0, 3, 0, 0, 0, 0, 0);
    en_i = 1'b1; finish_pass();
    chk(n_push == 1, "R6", "average push count", n_push, 1);
    chk(last_word[15:12] == 4'h5, "R12", "average channel field", last_word[15:12], 5);

    // R4 / R9 scan in low power, averaging ignored
    tag = "R9"; cfg(2'd2, 3, 0, 2, 1, 0, 1, 1, 4, 0, 0, 0);
    en_i = 1'b1; finish_pass();
    chk(n_push == 4, "R4", "scan push count", n_push, 4);
    chk(last_word[15:12] == 4'h3, "R4", "scan last channel", last_word[15:12], 3);
    chk(n_done == 1, "R4", "scan done count", n_done, 1);

    // R5 / R11 / R7 scan with burst, repeating, late and early valids
    tag = "R5"; cfg(2'd3, 2, 1, 0, 1, 0, 0, 0, 0, 1, 3, 1);
    en_i = 1'b1;
    while (n_done < 2) tick();
    en_i = 1'b0;
    repeat (30) tick();
    chk(n_push == 6, "R11", "repeat push count", n_push, 6);
    chk(n_done == 2, "R11", "repeat done count", n_done, 2);
    chk(last_word[15:12] == 4'hE, "R5", "scan burst final channel", last_word[15:12], 14);

    // R10 full FIFO drops and flags
    tag = "R10"; cfg(2'd1, 0, 2, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    fifo_full_i = 1'b1;
    en_i = 1'b1; finish_pass();
    fifo_full_i = 1'b0;
    chk(n_push == 0, "R10", "dropped pushes", n_push, 0);
    chk(ovf_o == 1'b1, "R10", "overflow set", ovf_o, 1);
    repeat (10) tick();
    chk(ovf_o == 1'b1, "R10", "overflow held", ovf_o, 1);
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0; tick();
    chk(ovf_o == 1'b0, "R10", "overflow cleared", ovf_o, 0);

    // R6 largest burst, R3 clamp of exponent
    tag = "R3"; cfg(2'd1, 0, 12, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    en_i = 1'b1; finish_pass();
    chk(n_push == 1, "R6", "256-sample average push", n_push, 1);
    chk(n_done == 1, "R3", "clamped burst done", n_done, 1);

    // R13 abort mid burst
    tag = "R13"; cfg(2'd1, 0, 3, 5, 0, 1, 0, 1, 2, 0, 0, 0);
    en_i = 1'b1;
    while (n_push < 2) tick();
    repeat (7) tick();
    en_i = 1'b0;
    repeat (60) tick();
    chk(n_push == 2, "R13", "no push after stop", n_push, 2);
    chk(adc_pwr_o == 1'b0, "R13", "power off after stop", adc_pwr_o, 0);
    chk(n_done == 0, "R13", "no done after stop", n_done, 0);

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule